// File: doc/BRIEF.md
# DMA Flash Window Checker

This block sits between a DMA engine and the flash read path and vets every DMA read before the transfer starts. Software programs three settings through a small write-only configuration port: a start address for the DMA-visible window, a window length counted in 2 KiB regions, and a master enable that opens flash to DMA at all. A separate input vector carries one protection bit per 2 KiB region of flash, and a low-power input says whether the device has left run mode.

For each request, the block finds the 2 KiB region that holds the address. The request passes only when all of these agree: the master enable is on, the region lies inside the window, the region's protection bit allows access, and the device is in run mode. The answer comes back one clock after the request is taken. It is a grant or a bus fault, never both. Only one request can be in flight, so the request-ready signal drops during the response cycle.

Top module: `dma_flash_window_checker`

## Requirements
- R1: After reset the master enable is off, the window start is 0, the window length is 0, `req_ready` is 1, and neither `resp_grant` nor `resp_fault` is asserted.
- R2: A configuration write with `cfg_sel` = 0 loads the window start from `cfg_wdata[ADDR_W-1:11]`. Bits 10:0 are ignored, so the start is 2 KiB aligned. `cfg_sel` = 1 loads the window length in regions from `cfg_wdata[ADDR_W-11:0]`. `cfg_sel` = 2 loads the master enable from `cfg_wdata[0]`. `cfg_sel` = 3 changes nothing.
- R3: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. In the following cycle exactly one of `resp_grant` and `resp_fault` is 1, for that single cycle. Neither is asserted at any other time.
- R4: `req_ready` is 0 in the response cycle. A request held valid through that cycle is not taken in it and yields no second response in the next cycle.
- R5: While the master enable is 0, every request faults.
- R6: With region index `i = addr >> 11`, start region `s` and length `n`, a request can be granted only if `s <= i < s+n`. There is no wrap past the top of flash. Any address outside this range faults.
- R7: A window length of 0 makes every request fault.
- R8: If `prot_allow[i]` is 0 for the region `i` holding the address, the request faults.
- R9: A request taken while `low_power` is 1 faults.
- R10: A request is granted when the enable is on, the address is inside the window, the region is allowed and `low_power` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 start, 1 length, 2 enable, 3 none |
| cfg_wdata | input | ADDR_W | Configuration write data |
| prot_allow | input | 2**(ADDR_W-11) | Per-region access bit; 1 allows DMA reads |
| low_power | input | 1 | 1 while the device is out of run mode |
| req_valid | input | 1 | DMA read request present |
| req_addr | input | ADDR_W | Flash byte address of the request |
| req_ready | output | 1 | Block can take a request this cycle |
| resp_grant | output | 1 | One-cycle pulse: the request may proceed |
| resp_fault | output | 1 | One-cycle pulse: the request gets a bus fault |

## Verification
A corrupted window register shows up on the very next request whose region sits near the window edge. It appears as a grant that should be a fault, or the reverse, one cycle after acceptance. A stuck busy state shows at once as `req_ready` staying low, or as a missing or doubled response pulse. For that reason each request is checked in the cycle its answer is due, and the bench probes the window boundaries, the region at the top of flash and the zero-length window directly.

// File: rtl/dfw_pkg.sv
package dfw_pkg;
  localparam int unsigned REGION_SHIFT = 11;

  typedef enum logic [1:0] {
    CFG_START  = 2'd0,
    CFG_LENGTH = 2'd1,
    CFG_ENABLE = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/dfw_cfg.sv
module dfw_cfg
  import dfw_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned RIDX_W = ADDR_W - REGION_SHIFT,
  parameter int unsigned LEN_W  = RIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [RIDX_W-1:0] start_idx,
  output logic [LEN_W-1:0]  win_len,
  output logic              dma_en
);
  logic [RIDX_W-1:0] start_q, start_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              en_q, en_d;
  logic              unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  always_comb begin
    start_d = start_q;
    len_d   = len_q;
    en_d    = en_q;
    if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        CFG_START:  start_d = cfg_wdata[ADDR_W-1:REGION_SHIFT];
        CFG_LENGTH: len_d   = cfg_wdata[LEN_W-1:0];
        CFG_ENABLE: en_d    = cfg_wdata[0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      len_q   <= '0;
      en_q    <= 1'b0;
    end else if (cfg_we) begin
      start_q <= start_d;
      len_q   <= len_d;
      en_q    <= en_d;
    end
  end

  assign start_idx = start_q;
  assign win_len   = len_q;
  assign dma_en    = en_q;

  p_ignored_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3) |=> ($stable(start_q) && $stable(len_q) && $stable(en_q)));
endmodule

// File: rtl/dfw_window.sv
module dfw_window #(
  parameter int unsigned RIDX_W = 9,
  parameter int unsigned LEN_W  = RIDX_W + 1
) (
  input  logic [RIDX_W-1:0] req_idx,
  input  logic [RIDX_W-1:0] start_idx,
  input  logic [LEN_W-1:0]  win_len,
  output logic              in_window
);
  logic [RIDX_W:0] offset;
  logic            below_start;

  always_comb begin
    offset      = {1'b0, req_idx} - {1'b0, start_idx};
    below_start = offset[RIDX_W];
    in_window   = !below_start && (offset < win_len);
  end
endmodule

// File: rtl/dfw_prot.sv
module dfw_prot #(
  parameter int unsigned RIDX_W  = 9,
  parameter int unsigned REGIONS = 1 << RIDX_W
) (
  input  logic [REGIONS-1:0] prot_allow,
  input  logic [RIDX_W-1:0]  req_idx,
  output logic               region_ok
);
  always_comb region_ok = prot_allow[req_idx];
endmodule

// File: rtl/dfw_resp.sv
module dfw_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic allow,
  output logic ready,
  output logic grant,
  output logic fault
);
  logic grant_q, grant_d;
  logic fault_q, fault_d;

  always_comb begin
    grant_d = accept && allow;
    fault_d = accept && !allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      grant_q <= grant_d;
      fault_q <= fault_d;
    end
  end

  assign ready = !(grant_q || fault_q);
  assign grant = grant_q;
  assign fault = fault_q;

  p_one_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && fault));
  p_answer_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (grant || fault));
  p_no_stray_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || fault) |-> $past(accept));
  p_no_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || fault) |=> !(grant || fault));
endmodule

// File: rtl/dma_flash_window_checker.sv
module dma_flash_window_checker
  import dfw_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  localparam int unsigned RIDX_W  = ADDR_W - REGION_SHIFT,
  localparam int unsigned LEN_W   = RIDX_W + 1,
  localparam int unsigned REGIONS = 1 << RIDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [ADDR_W-1:0]  cfg_wdata,
  input  logic [REGIONS-1:0] prot_allow,
  input  logic               low_power,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               req_ready,
  output logic               resp_grant,
  output logic               resp_fault
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [RIDX_W-1:0] req_idx;
  logic [RIDX_W-1:0] start_idx;
  logic [LEN_W-1:0]  win_len;
  logic              dma_en;
  logic              in_window;
  logic              region_ok;
  logic              accept;
  logic              allow;
  logic              unused_addr_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign req_idx        = req_addr[ADDR_W-1:REGION_SHIFT];
  assign unused_addr_lo = ^req_addr[REGION_SHIFT-1:0];

  dfw_cfg #(.ADDR_W(ADDR_W), .RIDX_W(RIDX_W), .LEN_W(LEN_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .start_idx (start_idx),
    .win_len   (win_len),
    .dma_en    (dma_en)
  );

  dfw_window #(.RIDX_W(RIDX_W), .LEN_W(LEN_W)) u_window (
    .req_idx   (req_idx),
    .start_idx (start_idx),
    .win_len   (win_len),
    .in_window (in_window)
  );

  dfw_prot #(.RIDX_W(RIDX_W), .REGIONS(REGIONS)) u_prot (
    .prot_allow (prot_allow),
    .req_idx    (req_idx),
    .region_ok  (region_ok)
  );

  assign accept = req_valid && req_ready;
  assign allow  = dma_en && in_window && region_ok && !low_power;

  dfw_resp u_resp (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .accept (accept),
    .allow  (allow),
    .ready  (req_ready),
    .grant  (resp_grant),
    .fault  (resp_fault)
  );

  p_disabled_faults_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && !dma_en) |=> resp_fault);
  p_outside_faults_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && (req_idx < start_idx)) |=> resp_fault);
  p_empty_window_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && win_len == '0) |=> resp_fault);
  p_masked_region_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && !region_ok) |=> resp_fault);
  p_low_power_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && low_power) |=> resp_fault);
  p_all_agree_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && dma_en && in_window && region_ok && !low_power) |=> resp_grant);
endmodule

// File: tb/dma_flash_window_checker_bench.sv
module dma_flash_window_checker_bench;
  localparam int ADDR_W  = 20;
  localparam int REGIONS = 1 << (ADDR_W - 11);

  logic               clk;
  logic               rst_n;
  logic               cfg_we;
  logic [1:0]         cfg_sel;
  logic [ADDR_W-1:0]  cfg_wdata;
  logic [REGIONS-1:0] prot_allow;
  logic               low_power;
  logic               req_valid;
  logic [ADDR_W-1:0]  req_addr;
  logic               req_ready;
  logic               resp_grant;
  logic               resp_fault;

  int  n_checks;
  int  n_fail;
  bit  done;
  int  m_start;
  int  m_len;
  bit  m_en;

  dma_flash_window_checker #(.ADDR_W(ADDR_W)) u_dma_flash_window_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .prot_allow (prot_allow),
    .low_power  (low_power),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .resp_grant (resp_grant),
    .resp_fault (resp_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_allow(input int addr, input bit lp);
    int idx;
    idx = addr >> 11;
    return m_en && (idx >= m_start) && (idx < m_start + m_len) &&
           prot_allow[idx] && !lp;
  endfunction

  task automatic cfg_write(input int sel, input int data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_sel   = sel[1:0];
    cfg_wdata = data[ADDR_W-1:0];
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 0) m_start = (data >> 11) & (REGIONS - 1);
    if (sel == 1) m_len = data & (2 * REGIONS - 1);
    if (sel == 2) m_en = data[0];
  endtask

  task automatic do_req(input int addr, input bit lp, input string req);
    bit exp_g;
    exp_g = model_allow(addr, lp);
    @(negedge clk);
    chk(req_ready == 1'b1, "R4 ready idle", int'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = addr[ADDR_W-1:0];
    low_power = lp;
    @(negedge clk);
    chk(resp_grant == exp_g && resp_fault == !exp_g, req,
        int'({resp_grant, resp_fault}), int'({exp_g, !exp_g}));
    chk(req_ready == 1'b0, "R4 ready in response", int'(req_ready), 0);
    req_valid = 1'b0;
    low_power = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    n_checks = 0; n_fail = 0; done = 1'b0;
    m_start = 0; m_len = 0; m_en = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
    prot_allow = '1; low_power = 1'b0; req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: idle outputs after reset
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(!resp_grant && !resp_fault, "R1 no response", int'({resp_grant, resp_fault}), 0);
    // R1/R5: enable is off after reset
    do_req(0, 1'b0, "R1 R5 enable reset off");
    cfg_write(2, 1);
    // R1/R7: length resets to zero
    do_req(0, 1'b0, "R1 R7 zero length");

    // R2: low start bits ignored, start region 8, length 4
    cfg_write(0, 32'h47FF);
    cfg_write(1, 4);
    do_req(32'h4000, 1'b0, "R2 R10 window start");
    do_req(32'h5FFF, 1'b0, "R6 R10 last byte in window");
    do_req(32'h6000, 1'b0, "R6 just past window");
    do_req(32'h3FFF, 1'b0, "R6 just below window");
    // R2: select 3 changes nothing
    cfg_write(3, 0);
    m_start = 8; m_len = 4; m_en = 1'b1;
    do_req(32'h4000, 1'b0, "R2 select 3 ignored");
    // R8: masked region
    prot_allow[9] = 1'b0;
    do_req(32'h4800, 1'b0, "R8 masked region");
    do_req(32'h5000, 1'b0, "R8 neighbour unaffected");
    prot_allow[9] = 1'b1;
    // R9: low power
    do_req(32'h4000, 1'b1, "R9 low power");
    // R7: zero length again
    cfg_write(1, 0);
    do_req(32'h4000, 1'b0, "R7 zero length");
    cfg_write(1, 4);
    // R5: enable cleared
    cfg_write(2, 0);
    do_req(32'h4000, 1'b0, "R5 disabled");
    cfg_write(2, 1);
    // R6: window at top of flash, no wrap
    cfg_write(0, (REGIONS - 2) << 11);
    do_req(32'hFFFFF, 1'b0, "R6 top region");
    do_req(0, 1'b0, "R6 no wrap");

    // R4: request held through the response cycle is not taken again
    @(negedge clk);
    req_valid = 1'b1; req_addr = 20'hFF000;
    @(negedge clk);
    chk(resp_grant == 1'b1, "R3 held request granted", int'(resp_grant), 1);
    @(negedge clk);
    chk(!resp_grant && !resp_fault, "R4 no second response",
        int'({resp_grant, resp_fault}), 0);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!resp_grant && !resp_fault, "R3 pulse is one cycle",
        int'({resp_grant, resp_fault}), 0);

    // Random phase
    for (int k = 0; k < 400; k++) begin
      int a;
      bit lp;
      if (k % 25 == 0) begin
        for (int r = 0; r < REGIONS; r++) prot_allow[r] = ($urandom % 8) != 0;
        cfg_write(0, (($urandom % REGIONS) << 11) | ($urandom % 2048));
        cfg_write(1, $urandom % 40);
        cfg_write(2, ($urandom % 8) != 0);
      end
      if ($urandom % 2 == 0)
        a = ((((m_start + ($urandom % (m_len + 4))) - 2) & (REGIONS - 1)) << 11) |
            ($urandom % 2048);
      else
        a = $urandom % (1 << ADDR_W);
      lp = ($urandom % 10) == 0;
      do_req(a, lp, "R10 random request");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule